// File: doc/BRIEF.md
# Shared Ready/Data Serial Reader

This block sits on the host side of a serial link to a data converter. The converter uses a single line for two purposes. While no transfer is running, a low level on the line says a fresh conversion result is waiting. During a transfer, the same line carries the result bits. The reader synchronizes the line into its clock domain and waits for a confirmed low level. It then drives a serial clock and collects a 24-bit word, most significant bit first. It presents the word in parallel with a single-cycle strobe.

The width of each serial clock phase is set by a configuration input, counted in system-clock cycles. A parameter sets a floor on that width, so that neither phase drops below the converter's minimum pulse width. Each bit is captured in the last cycle of the clock-high phase. That is well after the converter's output delay, even when the two synchronizer cycles are added. An optional extra clock pulse after the last bit makes the converter drive the line high again, so that the next ready event arrives as a clean high-to-low change. After every read the block stays inert until it has seen the line high. This keeps one result from being read twice.

Top module: `ready_data_reader`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `sclk_o` is 0, `word_vld_o` is 0 and `word_o` is all zeros.
- R2: A read starts only after the line, delayed by two synchronizer flops, reads low on two consecutive system clocks. A low pulse lasting one system clock never produces a `sclk_o` rising edge.
- R3: A read can start only if the synchronized line has been seen high since reset or since the end of the previous read. A line left low after a read produces no further `sclk_o` edges.
- R4: A read captures 24 bits, one per `sclk_o` pulse, with the first captured bit placed at `word_o[23]` and the last at `word_o[0]`.
- R5: Every high phase of `sclk_o`, and every low phase between pulses of one read, lasts P system clocks. P is `cfg_phase_i` (8 bits, unsigned), raised to `MIN_PHASE` (default 10) when smaller. P is sampled when the read starts.
- R6: Each bit is sampled in the last system clock of its `sclk_o` high phase. A bit driven within 5 system clocks of the rising edge is therefore captured correctly.
- R7: With `cfg_flush_i` = 1 at read start, a read issues exactly 25 `sclk_o` rising edges; with 0 it issues exactly 24. The 25th pulse captures nothing.
- R8: `word_vld_o` is high for exactly one system clock per read. `word_o` changes only on the cycle in which `word_vld_o` is high.
- R9: `sclk_o` is low whenever no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sdata_i | input | 1 | Shared ready/data line from the converter (asynchronous) |
| cfg_phase_i | input | 8 | Serial clock phase length in system clocks, floored at MIN_PHASE |
| cfg_flush_i | input | 1 | 1 = issue the extra clock pulse that returns the line high |
| sclk_o | output | 1 | Serial clock to the converter |
| word_o | output | 24 | Last complete result word |
| word_vld_o | output | 1 | One-cycle strobe marking a new `word_o` |

## Verification
On every cycle, the assertions check the following. The strobe lasts one cycle, and the result word changes only under it. The phase counter stays below the latched phase length. The serial clock is low outside a read. The pulse count never passes 24, or 25 with the extra pulse. A read never leaves idle while the block is disarmed. Some behaviour can only be shown by the bench's scenarios, because it needs a converter model driving bits after each rising edge. This covers bit order and the sampling point, the measured phase widths and the floor, the exact pulse counts with and without the extra pulse, rejection of a single-cycle low glitch, and the refusal to re-read a line left low.

// File: rtl/rdr_pkg.sv
`timescale 1ns/1ps
package rdr_pkg;
  typedef enum logic [1:0] {
    RD_IDLE = 2'd0,
    RD_HIGH = 2'd1,
    RD_LOW  = 2'd2
  } rd_state_t;
endpackage

// File: rtl/rdr_sync.sv
`timescale 1ns/1ps
module rdr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '1;
    else     chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/rdr_phase_timer.sv
`timescale 1ns/1ps
module rdr_phase_timer #(
  parameter int PHASE_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run_i,
  input  logic [PHASE_W-1:0] len_i,
  output logic               done_o
);
  logic [PHASE_W-1:0] cnt_q;

  assign done_o = run_i && (cnt_q == len_i - PHASE_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run_i) cnt_q <= '0;
    else if (done_o)   cnt_q <= '0;
    else               cnt_q <= cnt_q + PHASE_W'(1);
  end

  // R5
  phase_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run_i |-> (cnt_q < len_i));
endmodule

// File: rtl/rdr_shift.sv
`timescale 1ns/1ps
module rdr_shift #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_i,
  input  logic              last_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o,
  output logic              vld_o
);
  logic [WORD_W-1:0] shreg_q;
  logic [WORD_W-1:0] next_w;

  assign next_w = {shreg_q[WORD_W-2:0], bit_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '0;
      word_o  <= '0;
      vld_o   <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (sample_i) begin
        shreg_q <= next_w;
        if (last_i) begin
          word_o <= next_w;
          vld_o  <= 1'b1;
        end
      end
    end
  end

  // R8
  vld_single_chk: assert property (@(posedge clk) disable iff (rst)
    vld_o |=> !vld_o);
  // R8
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !vld_o |=> (!vld_o |-> $stable(word_o)));
endmodule

// File: rtl/ready_data_reader.sv
`timescale 1ns/1ps
module ready_data_reader
  import rdr_pkg::*;
#(
  parameter int WORD_W    = 24,
  parameter int PHASE_W   = 8,
  parameter int MIN_PHASE = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sdata_i,
  input  logic [PHASE_W-1:0] cfg_phase_i,
  input  logic               cfg_flush_i,
  output logic               sclk_o,
  output logic [WORD_W-1:0]  word_o,
  output logic               word_vld_o
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [PHASE_W-1:0] MIN_P  = PHASE_W'(MIN_PHASE);
  localparam logic [CNT_W-1:0]   LAST_D = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0]   LAST_F = CNT_W'(WORD_W + 1);

  rd_state_t          st_q;
  logic               line;
  logic               armed_q, prev_low_q, flush_q;
  logic [PHASE_W-1:0] plen_q;
  logic [CNT_W-1:0]   pulses_q;
  logic               phase_done, start, sample;

  rdr_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .async_i(sdata_i), .sync_o(line)
  );

  rdr_phase_timer #(.PHASE_W(PHASE_W)) u_timer (
    .clk(clk), .rst(rst), .run_i(st_q != RD_IDLE),
    .len_i(plen_q), .done_o(phase_done)
  );

  assign start  = (st_q == RD_IDLE) && armed_q && !line && prev_low_q;
  assign sample = (st_q == RD_HIGH) && phase_done && (pulses_q < LAST_D);

  rdr_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .sample_i(sample),
    .last_i(pulses_q == LAST_D - CNT_W'(1)), .bit_i(line),
    .word_o(word_o), .vld_o(word_vld_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= RD_IDLE;
      sclk_o     <= 1'b0;
      armed_q    <= 1'b0;
      prev_low_q <= 1'b0;
      flush_q    <= 1'b0;
      plen_q     <= MIN_P;
      pulses_q   <= '0;
    end else begin
      case (st_q)
        RD_IDLE: begin
          prev_low_q <= !line;
          if (line) armed_q <= 1'b1;
          if (start) begin
            st_q     <= RD_HIGH;
            sclk_o   <= 1'b1;
            plen_q   <= (cfg_phase_i < MIN_P) ? MIN_P : cfg_phase_i;
            flush_q  <= cfg_flush_i;
            pulses_q <= '0;
          end
        end
        RD_HIGH: begin
          if (phase_done) begin
            st_q     <= RD_LOW;
            sclk_o   <= 1'b0;
            pulses_q <= pulses_q + CNT_W'(1);
          end
        end
        RD_LOW: begin
          if (phase_done) begin
            if (pulses_q == (flush_q ? LAST_F : LAST_D)) begin
              st_q       <= RD_IDLE;
              armed_q    <= 1'b0;
              prev_low_q <= 1'b0;
            end else begin
              st_q   <= RD_HIGH;
              sclk_o <= 1'b1;
            end
          end
        end
        default: begin
          st_q   <= RD_IDLE;
          sclk_o <= 1'b0;
        end
      endcase
    end
  end

  // R9
  idle_clk_low_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == RD_IDLE) |-> !sclk_o);
  // R7
  pulse_limit_chk: assert property (@(posedge clk) disable iff (rst)
    pulses_q <= LAST_F);
  // R3
  disarmed_stay_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == RD_IDLE && !armed_q) |=> (st_q == RD_IDLE));
endmodule

// File: tb/sim_ready_data_reader.sv
`timescale 1ns/1ps
module sim_ready_data_reader;
  localparam int W = 24;
  localparam int MINP = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sdata = 1'b1;
  logic [7:0]  cfg_phase = 8'd10;
  logic        cfg_flush = 1'b0;
  logic        sclk;
  logic [W-1:0] word;
  logic        vld;

  int n_chk = 0, n_fail = 0;
  int edges = 0, vld_cnt = 0, hi_run = 0, hi_last = 0, lo_run = 0, lo_last = 0;
  logic [W-1:0] cap = '0;
  bit done = 0;

  always #5 clk = ~clk;

  ready_data_reader u0 (
    .clk(clk), .rst(rst), .sdata_i(sdata), .cfg_phase_i(cfg_phase),
    .cfg_flush_i(cfg_flush), .sclk_o(sclk), .word_o(word), .word_vld_o(vld)
  );

  always @(posedge sclk) edges++;

  always @(negedge clk) begin
    if (vld) begin vld_cnt++; cap = word; end
    if (sclk) begin
      if (lo_run > 0) begin lo_last = lo_run; lo_run = 0; end
      hi_run++;
    end else begin
      if (hi_run > 0) begin hi_last = hi_run; hi_run = 0; end
      lo_run++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // converter model: line low = ready, then one bit after each rising clock
  task automatic serve(input logic [W-1:0] d, input logic fl, input int p);
    edges = 0; vld_cnt = 0;
    @(negedge clk) sdata = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      @(posedge sclk);
      #3 sdata = d[i];
    end
    if (fl) begin
      @(posedge sclk);
      #3 sdata = 1'b1;
    end
    cycles(2 * p + 8);
  endtask

  // {data, flush, phase}
  localparam logic [32:0] VEC [6] = '{
    {24'hA5C3F1, 1'b1, 8'd10},
    {24'h000001, 1'b1, 8'd12},
    {24'h800000, 1'b1, 8'd3},
    {24'hFFFFFF, 1'b0, 8'd10},
    {24'h5A5A5B, 1'b0, 8'd15},
    {24'h123457, 1'b1, 8'd0}
  };

  initial begin
    cycles(3);
    // R1 reset state
    check("R1 sclk", sclk, 0);
    check("R1 vld", vld, 0);
    check("R1 word", word, 0);
    @(negedge clk) rst = 1'b0;
    check("R1 sclk after release", sclk, 0);
    check("R1 word after release", word, 0);
    cycles(10);

    foreach (VEC[k]) begin
      logic [W-1:0] d;
      logic fl;
      int p, ep;
      d = VEC[k][32:9]; fl = VEC[k][8]; p = int'(VEC[k][7:0]);
      ep = (p < MINP) ? MINP : p;
      cfg_phase = VEC[k][7:0]; cfg_flush = fl;
      serve(d, fl, ep);
      check("R4 R6 word bits msb first", cap, d);
      check("R8 one strobe", vld_cnt, 1);
      check("R7 pulse count", edges, fl ? 25 : 24);
      check("R5 high width", hi_last, ep);
      check("R5 low width", lo_last, ep);
      check("R9 clock idle low", sclk, 0);
      if (!fl) @(negedge clk) sdata = 1'b1;
      cycles(6);
    end

    // R2: one-cycle low glitch must not start a read
    edges = 0;
    cycles(5);
    @(negedge clk) sdata = 1'b0;
    @(negedge clk) sdata = 1'b1;
    cycles(60);
    check("R2 glitch ignored", edges, 0);

    // R3: line left low after a read (last bit 0, no flush) must not re-trigger
    cfg_phase = 8'd10; cfg_flush = 1'b0;
    serve(24'hC0FFEE, 1'b0, 10);
    check("R4 word before hold", cap, 24'hC0FFEE);
    edges = 0;
    cycles(200);
    check("R3 no re-read while low", edges, 0);
    check("R8 word unchanged", word, 24'hC0FFEE);
    // after the line returns high, the block rearms
    @(negedge clk) sdata = 1'b1;
    cycles(5);
    cfg_flush = 1'b1;
    serve(24'h3C3C3C, 1'b1, 10);
    check("R3 rearmed read", cap, 24'h3C3C3C);

    // R1: reset in the middle of a read
    edges = 0;
    @(negedge clk) sdata = 1'b0;
    cycles(30);
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    check("R1 sclk mid-read reset", sclk, 0);
    check("R1 word mid-read reset", word, 0);
    sdata = 1'b1;
    @(negedge clk) rst = 1'b0;
    cycles(5);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule